// File: doc/BRIEF.md
# Memory Address Router

The router sits between a processor's load/store path and two memories: a small on-chip RAM and the external memory interface. Each cycle it examines a 32-bit byte address. If the address falls inside a fixed 2 KB window at the bottom of the signed address space, and on-chip RAM is enabled, the access goes to the on-chip RAM. Every other address raises a request to the external interface. The router also supplies the word index and byte-lane enables that the RAM needs for sub-word writes.

On-chip RAM can be switched off with a configuration pin. The router captures this pin while reset is held and keeps that value until the next reset. While an internal access is under way, the router mirrors it onto the external bus pins one cycle later: the word address, a low-active write indication, and a refresh/data pin forced high. If a refresh or DMA transfer claims the bus in the same cycle, the mirror is withdrawn so that the external engine owns the pins.

Top module: `mem_addr_router`

## Requirements
- R1: An access whose byte address lies from 0x80000000 to 0x800007FF inclusive is routed to on-chip RAM (`iram_sel`=1, `ext_req`=0). Every other address is routed externally (`ext_req`=1, `iram_sel`=0). Routing is combinational in the cycle of `req`.
- R2: While the captured disable value is 1, every request, including those inside the internal window, is routed externally.
- R3: The disable value is taken from `iram_off_pin` on each clock edge while `rst` is high. After `rst` falls, changes on the pin have no effect until the next reset.
- R4: With `req`=0 neither `iram_sel` nor `ext_req` is asserted. With `req`=1 exactly one of them is asserted. `iram_wr` equals `iram_sel` AND `wr`.
- R5: `iram_idx` is the word offset inside the window, byte address bits 10:2.
- R6: `lane_be` is little-endian, with bit n enabling the byte at address offset n. The `size` encoding is 00 for a byte (`lane_be` = 1 << addr[1:0]), 01 for a halfword (0011 if addr[1]=0, 1100 if addr[1]=1, addr[0] ignored), and 10 or 11 for a word (1111).
- R7: `iram_done` is 1 exactly in the cycle after a cycle with `iram_sel`=1.
- R8: In the cycle after an internal access with `refresh_busy`=0 and `dma_busy`=0, the outputs are `bus_mirror`=1, `bus_ad` = access address bits 31:2, `bus_nwr` = NOT `wr`, and `bus_rfd1`=1.
- R9: In the cycle after any cycle that is not an unblocked internal access, including internal accesses with `refresh_busy` or `dma_busy` high, the outputs are `bus_mirror`, `bus_ad`, `bus_nwr` and `bus_rfd1` all 0.
- R10: While `rst` is high, after a clock edge the outputs `iram_done`, `bus_mirror`, `bus_ad`, `bus_nwr` and `bus_rfd1` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| iram_off_pin | input | 1 | Disable on-chip RAM; captured during reset |
| req | input | 1 | Access request this cycle |
| addr | input | 32 | Byte address |
| wr | input | 1 | 1 = write, 0 = read |
| size | input | 2 | Access size: 00 byte, 01 halfword, 1x word |
| refresh_busy | input | 1 | Refresh cycle owns the external bus |
| dma_busy | input | 1 | DMA transfer owns the external bus |
| iram_sel | output | 1 | Access goes to on-chip RAM |
| iram_wr | output | 1 | On-chip RAM write strobe |
| iram_idx | output | 9 | On-chip RAM word index |
| lane_be | output | 4 | Byte-lane enables |
| ext_req | output | 1 | Access goes to external interface |
| iram_done | output | 1 | On-chip access completed |
| bus_mirror | output | 1 | Router drives the bus pins with the mirror |
| bus_ad | output | 30 | Mirrored word address, bits 31:2 |
| bus_nwr | output | 1 | Mirrored direction, low for write |
| bus_rfd1 | output | 1 | Refresh/data1 pin value, high while mirroring |

## Verification
Routing, word index, lane enables and the RAM write strobe are combinational. The bench therefore checks them one time step after it drives the inputs at the falling edge, within the same cycle. Completion and the bus mirror each pass through one register, so they are due after the next rising edge. The bench checks them one time step after that edge, against expectations computed from the inputs of the previous cycle. The disable capture is checked across reset release: the bench flips the pin afterwards and expects no change in routing.

// File: rtl/mar_pkg.sv
package mar_pkg;

    localparam int ADDR_W   = 32;
    localparam int WORD_LSB = 2;
    localparam int LANES    = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WRD2 = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic to_int;
        logic to_ext;
    } route_t;

    typedef struct packed {
        logic                          valid;
        logic [ADDR_W-WORD_LSB-1:0]    word;
        logic                          nwr;
    } mirror_t;

    function automatic logic [LANES-1:0] lane_mask(input acc_size_e sz,
                                                   input logic [1:0] lo);
        logic [LANES-1:0] m;
        case (sz)
            SZ_BYTE: m = 4'b0001 << lo;
            SZ_HALF: m = lo[1] ? 4'b1100 : 4'b0011;
            default: m = 4'b1111;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/mar_cfg_latch.sv
module mar_cfg_latch (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic off_q
);
    // Tracks the pin only while reset is held; frozen afterwards.
    always_ff @(posedge clk) begin
        if (rst) begin
            off_q <= pin;
        end
    end
endmodule

// File: rtl/mar_decode.sv
module mar_decode
    import mar_pkg::*;
#(
    parameter logic [ADDR_W-1:0] IRAM_BASE  = 32'h8000_0000,
    parameter int                IRAM_BYTES = 2048,
    localparam int               OFF_W      = $clog2(IRAM_BYTES),
    localparam int               IDX_W      = OFF_W - WORD_LSB
) (
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              off,
    output route_t            route,
    output logic [IDX_W-1:0]  idx,
    output logic [LANES-1:0]  be
);
    logic hit;

    always_comb begin
        hit          = (addr[ADDR_W-1:OFF_W] == IRAM_BASE[ADDR_W-1:OFF_W]);
        route.to_int = req & hit & ~off;
        route.to_ext = req & ~(hit & ~off);
        idx          = addr[OFF_W-1:WORD_LSB];
        be           = lane_mask(acc_size_e'(size), addr[1:0]);
    end
endmodule

// File: rtl/mar_bus_mirror.sv
module mar_bus_mirror
    import mar_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       int_acc,
    input  logic                       busy,
    input  logic [ADDR_W-WORD_LSB-1:0] word,
    input  logic                       wr,
    output logic                       done,
    output mirror_t                    mir
);
    mirror_t nxt;

    always_comb begin
        nxt       = '0;
        nxt.valid = int_acc & ~busy;
        if (nxt.valid) begin
            nxt.word = word;
            nxt.nwr  = ~wr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
            mir  <= '0;
        end else begin
            done <= int_acc;
            mir  <= nxt;
        end
    end
endmodule

// File: rtl/mem_addr_router.sv
module mem_addr_router
    import mar_pkg::*;
#(
    parameter logic [ADDR_W-1:0] IRAM_BASE  = 32'h8000_0000,
    parameter int                IRAM_BYTES = 2048,
    localparam int               OFF_W      = $clog2(IRAM_BYTES),
    localparam int               IDX_W      = OFF_W - WORD_LSB
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       iram_off_pin,
    input  logic                       req,
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       wr,
    input  logic [1:0]                 size,
    input  logic                       refresh_busy,
    input  logic                       dma_busy,
    output logic                       iram_sel,
    output logic                       iram_wr,
    output logic [IDX_W-1:0]           iram_idx,
    output logic [LANES-1:0]           lane_be,
    output logic                       ext_req,
    output logic                       iram_done,
    output logic                       bus_mirror,
    output logic [ADDR_W-WORD_LSB-1:0] bus_ad,
    output logic                       bus_nwr,
    output logic                       bus_rfd1
);
    logic    off_q;
    route_t  route;
    mirror_t mir;

    mar_cfg_latch u_cfg (
        .clk   (clk),
        .rst   (rst),
        .pin   (iram_off_pin),
        .off_q (off_q)
    );

    mar_decode #(
        .IRAM_BASE  (IRAM_BASE),
        .IRAM_BYTES (IRAM_BYTES)
    ) u_dec (
        .req   (req),
        .addr  (addr),
        .size  (size),
        .off   (off_q),
        .route (route),
        .idx   (iram_idx),
        .be    (lane_be)
    );

    mar_bus_mirror u_mir (
        .clk     (clk),
        .rst     (rst),
        .int_acc (route.to_int),
        .busy    (refresh_busy | dma_busy),
        .word    (addr[ADDR_W-1:WORD_LSB]),
        .wr      (wr),
        .done    (iram_done),
        .mir     (mir)
    );

    assign iram_sel   = route.to_int;
    assign ext_req    = route.to_ext;
    assign iram_wr    = route.to_int & wr;
    assign bus_mirror = mir.valid;
    assign bus_ad     = mir.word;
    assign bus_nwr    = mir.nwr;
    assign bus_rfd1   = mir.valid;
endmodule

// File: rtl/mar_checker.sv
module mar_checker #(
    parameter logic [31:0] BASE  = 32'h8000_0000,
    parameter int          BYTES = 2048
) (
    input logic        clk,
    input logic        rst,
    input logic        off_q,
    input logic        req,
    input logic [31:0] addr,
    input logic [1:0]  size,
    input logic        refresh_busy,
    input logic        dma_busy,
    input logic        iram_sel,
    input logic        ext_req,
    input logic [3:0]  lane_be,
    input logic        iram_done,
    input logic        bus_mirror,
    input logic [29:0] bus_ad,
    input logic        bus_rfd1
);
    localparam logic [31:0] LAST = BASE + 32'(BYTES) - 32'd1;

    logic live_q;
    always_ff @(posedge clk) begin
        if (rst) live_q <= 1'b0;
        else     live_q <= 1'b1;
    end

    assert_window_R1: assert property (@(posedge clk) disable iff (rst)
        (req && !off_q && addr >= BASE && addr <= LAST) |-> iram_sel);

    assert_off_external_R2: assert property (@(posedge clk) disable iff (rst)
        (req && off_q) |-> (ext_req && !iram_sel));

    assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        live_q |-> $stable(off_q));

    assert_one_target_R4: assert property (@(posedge clk) disable iff (rst)
        $countones({iram_sel, ext_req}) == (req ? 1 : 0));

    assert_byte_lane_R6: assert property (@(posedge clk) disable iff (rst)
        (req && size == 2'b00) |-> $countones(lane_be) == 1);

    assert_done_R7: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (iram_done == $past(iram_sel)));

    assert_mirror_R8: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(iram_sel) && !$past(refresh_busy) && !$past(dma_busy))
        |-> (bus_mirror && bus_rfd1 && bus_ad == $past(addr[31:2])));

    assert_override_R9: assert property (@(posedge clk) disable iff (rst)
        (live_q && ($past(refresh_busy) || $past(dma_busy) || !$past(iram_sel)))
        |-> (!bus_mirror && !bus_rfd1));
endmodule

bind mem_addr_router mar_checker #(
    .BASE  (IRAM_BASE),
    .BYTES (IRAM_BYTES)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .off_q        (off_q),
    .req          (req),
    .addr         (addr),
    .size         (size),
    .refresh_busy (refresh_busy),
    .dma_busy     (dma_busy),
    .iram_sel     (iram_sel),
    .ext_req      (ext_req),
    .lane_be      (lane_be),
    .iram_done    (iram_done),
    .bus_mirror   (bus_mirror),
    .bus_ad       (bus_ad),
    .bus_rfd1     (bus_rfd1)
);

// File: tb/mem_addr_router_tb.sv
module mem_addr_router_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iram_off_pin = 1'b0;
    logic        req = 1'b0;
    logic [31:0] addr = '0;
    logic        wr = 1'b0;
    logic [1:0]  size = 2'b10;
    logic        refresh_busy = 1'b0;
    logic        dma_busy = 1'b0;
    logic        iram_sel, iram_wr, ext_req, iram_done;
    logic [8:0]  iram_idx;
    logic [3:0]  lane_be;
    logic        bus_mirror, bus_nwr, bus_rfd1;
    logic [29:0] bus_ad;

    int total = 0;
    int bad   = 0;
    logic ref_off = 1'b0;

    always #5 clk = ~clk;

    mem_addr_router u_dut (
        .clk(clk), .rst(rst), .iram_off_pin(iram_off_pin), .req(req),
        .addr(addr), .wr(wr), .size(size), .refresh_busy(refresh_busy),
        .dma_busy(dma_busy), .iram_sel(iram_sel), .iram_wr(iram_wr),
        .iram_idx(iram_idx), .lane_be(lane_be), .ext_req(ext_req),
        .iram_done(iram_done), .bus_mirror(bus_mirror), .bus_ad(bus_ad),
        .bus_nwr(bus_nwr), .bus_rfd1(bus_rfd1)
    );

    task automatic chk(input string tag, input string what,
                       input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_be(input logic [1:0] s, input logic [31:0] a);
        int ofs = int'(a % 4);
        if (s == 2'b00) return 4'(1 << ofs);
        if (s == 2'b01) return (ofs < 2) ? 4'd3 : 4'd12;
        return 4'd15;
    endfunction

    // One cycle: drive at falling edge, check comb at once, registered after next rise.
    task automatic run(input logic r, input logic [31:0] a, input logic w,
                       input logic [1:0] s, input logic rf, input logic dm);
        logic in_win, e_sel, e_mir;
        @(negedge clk);
        req = r; addr = a; wr = w; size = s; refresh_busy = rf; dma_busy = dm;
        #1;
        in_win = (a >= 32'h8000_0000) && (a <= 32'h8000_07FF);
        e_sel  = r && in_win && !ref_off;
        chk(ref_off ? "R2" : "R1", "iram_sel", iram_sel, e_sel);
        chk("R4", "ext_req", ext_req, r && !e_sel);
        chk("R4", "iram_wr", iram_wr, e_sel && w);
        if (e_sel) chk("R5", "iram_idx", iram_idx, (a - 32'h8000_0000) / 4);
        if (r) chk("R6", "lane_be", lane_be, exp_be(s, a));
        e_mir = e_sel && !rf && !dm;
        @(posedge clk);
        #1;
        chk("R7", "iram_done", iram_done, e_sel);
        chk(e_mir ? "R8" : "R9", "bus_mirror", bus_mirror, e_mir);
        chk(e_mir ? "R8" : "R9", "bus_ad", bus_ad, e_mir ? a / 4 : 0);
        chk(e_mir ? "R8" : "R9", "bus_nwr", bus_nwr, e_mir ? !w : 1'b0);
        chk(e_mir ? "R8" : "R9", "bus_rfd1", bus_rfd1, e_mir);
    endtask

    task automatic do_reset(input logic pin);
        @(negedge clk);
        rst = 1'b1; iram_off_pin = pin; req = 1'b1;
        addr = 32'h8000_0010; wr = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R10", "done in reset", iram_done, 0);
        chk("R10", "mirror in reset", bus_mirror, 0);
        chk("R10", "ad in reset", bus_ad, 0);
        chk("R10", "nwr in reset", bus_nwr, 0);
        chk("R10", "rfd1 in reset", bus_rfd1, 0);
        @(negedge clk);
        rst = 1'b0; req = 1'b0;
        ref_off = pin;
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // Disabled RAM: everything external (R2)
        do_reset(1'b1);
        run(1, 32'h8000_0000, 0, 2'b10, 0, 0);
        run(1, 32'h8000_07FC, 1, 2'b00, 0, 0);
        // Pin change after reset is ignored (R3)
        iram_off_pin = 1'b0;
        run(1, 32'h8000_0100, 1, 2'b10, 0, 0);
        run(1, 32'h8000_0004, 0, 2'b01, 0, 0);

        // Enabled RAM
        do_reset(1'b0);
        run(0, 32'h8000_0000, 0, 2'b10, 0, 0);                // R4 idle
        run(1, 32'h8000_0000, 1, 2'b10, 0, 0);                // R1 low edge
        run(1, 32'h8000_07FF, 0, 2'b00, 0, 0);                // R1 high edge
        run(1, 32'h8000_0800, 1, 2'b10, 0, 0);                // just above
        run(1, 32'h7FFF_FFFF, 0, 2'b00, 0, 0);                // just below
        run(1, 32'h0000_0000, 0, 2'b10, 0, 0);
        run(1, 32'hFFFF_FFFF, 1, 2'b01, 0, 0);
        iram_off_pin = 1'b1;                                  // R3 ignored
        run(1, 32'h8000_0200, 1, 2'b10, 1, 0);                // R9 refresh
        run(1, 32'h8000_0204, 0, 2'b10, 0, 1);                // R9 dma
        run(1, 32'h8000_0208, 1, 2'b11, 1, 1);
        run(1, 32'h8000_020C, 0, 2'b10, 0, 0);                // R8 after override
        // Lane patterns (R6)
        for (int o = 0; o < 4; o++) begin
            run(1, 32'h8000_0040 + 32'(o), 1, 2'b00, 0, 0);
            run(1, 32'h8000_0040 + 32'(o), 1, 2'b01, 0, 0);
        end
        // Back-to-back internal then external (R7, R9)
        run(1, 32'h8000_0300, 0, 2'b10, 0, 0);
        run(1, 32'h1234_5678, 1, 2'b10, 0, 0);
        run(0, 32'h8000_0300, 1, 2'b10, 0, 0);
        // Sweep
        for (int i = 0; i < 120; i++) begin
            run(1'(i % 7 != 0), 32'h7FFF_FE00 + 32'(i * 29), 1'(i % 2),
                2'(i % 4), 1'(i % 11 == 3), 1'(i % 13 == 5));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule